// File: doc/BRIEF.md
# Byte-Serial DMA Engine with Local Scratch Buffer

This block is a single-channel copy engine for a device that keeps a private 4096-byte scratch buffer in its own address space, starting at device offset 0x40000. Software fills four registers: a source address, a destination address, a byte count and a command word. The command word starts the copy and picks its direction. One end of the copy is always the scratch buffer. The other end is host memory, which is reached through a simple request/acknowledge memory master port.

The direction bit decides which address register holds the host side and which holds the device side. Before any memory traffic, the engine checks both addresses. The host address must fit under a 28-bit DMA mask. The device range must lie wholly inside the scratch window. A failed check drops the job at once, with no interrupt. Data moves one byte per memory handshake, in ascending address order. The start bit reads back as a busy flag until the job ends, so a driver can poll it. While it is set, the configuration registers are locked. On a clean finish the engine can give a one-cycle completion pulse, which upstream logic turns into interrupt cause 0x100.

Top module: `hostbuf_dma`

## Requirements
- R1: After reset every configuration register reads zero, the busy flag is clear, and neither `mem_req` nor `done_irq` is asserted.
- R2: Register offsets are 0x80 (source), 0x88 (destination), 0x90 (count) and 0x98 (command). An access with `cfg_wide`=1 at an 8-aligned offset moves all 64 bits. An access with `cfg_wide`=0 moves 32 bits: offset bit 2 picks the upper half, and read data sits in bits 31:0 with the upper bits zero.
- R3: Command bit 0 is start and busy, bit 1 is direction, and bit 2 is completion-pulse enable. Writing bit 0 as 1 while idle begins a job, and bit 0 then reads 1 until the job ends. Writing bit 0 as 0 only stores bits 1 and 2.
- R4: With direction 0, byte i is read from host address source+i and stored at scratch offset (destination−0x40000)+i.
- R5: With direction 1, scratch offset (source−0x40000)+i is written to host address destination+i.
- R6: Each byte uses one handshake. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`. Host addresses step up by one from the start address, and exactly count handshakes take place.
- R7: On a clean finish with bit 2 set, `done_irq` is high for exactly one cycle, and busy reads 0 from the next cycle on. With bit 2 clear, no pulse is given.
- R8: If the device address is below 0x40000, or device address + count exceeds 0x41000, the job is dropped: no memory request, no pulse, and busy clears.
- R9: If the host address has any bit set at or above bit 28, the job is dropped in the same way.
- R10: Writes to any of the four registers while busy reads 1 are ignored, including a start written in the job's final cycle. Once idle, writes take effect.
- R11: A count of zero that passes the checks finishes with no memory request and still gives the pulse if bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wide | input | 1 | 1: 64-bit access, 0: 32-bit access |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data (combinational) |
| mem_req | output | 1 | Host memory request, held until acknowledged |
| mem_we | output | 1 | 1: write to host, 0: read from host |
| mem_addr | output | 64 | Host byte address |
| mem_wdata | output | 8 | Byte written to host |
| mem_rdata | input | 8 | Byte returned by host, valid with mem_ack |
| mem_ack | input | 1 | Host response valid, one cycle per request |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
A register write can arrive in the same cycle that the engine finishes a job. In that cycle `done_irq` is high and busy still reads 1, so the lock must win. The bench polls for the pulse away from the clock edge and drives a destination write in that very cycle. It then checks that the old destination value survives, that busy is clear one cycle later, and that a repeat of the write once idle is accepted. A start command issued mid-job is judged the same way: the host handshake count must equal the first job's byte count.

// File: rtl/dma_buf_pkg.sv
package dma_buf_pkg;
  localparam int REG_W = 64;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_MOVE  = 2'd2,
    ST_DONE  = 2'd3
  } xfer_state_e;

  // register slot index taken from offset bits [4:3]
  localparam logic [1:0] SLOT_SRC = 2'd0;
  localparam logic [1:0] SLOT_DST = 2'd1;
  localparam logic [1:0] SLOT_CNT = 2'd2;
  localparam logic [1:0] SLOT_CMD = 2'd3;

  localparam int CMD_GO  = 0;
  localparam int CMD_DIR = 1;
  localparam int CMD_IRQ = 2;
endpackage

// File: rtl/dma_lbuf.sv
module dma_lbuf #(
  parameter int DEPTH = 4096,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_buf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_wide,
  input  logic [7:0]       cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             busy_i,
  output logic             start_o,
  output logic [REG_W-1:0] src_o,
  output logic [REG_W-1:0] dst_o,
  output logic [REG_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             irq_en_o
);
  localparam int NSLOT = 3;
  localparam int HALF  = REG_W / 2;

  logic [NSLOT-1:0][REG_W-1:0] slot_q, slot_d;
  logic       dir_q, dir_d, irq_q, irq_d;
  logic       in_win, acc_ok, wr_ok, hi;
  logic [1:0] sel;
  logic       cmd_wr;
  logic [REG_W-1:0] val;

  assign in_win = (cfg_addr[7:5] == 3'b100) && (cfg_addr[1:0] == 2'b00);
  assign sel    = cfg_addr[4:3];
  assign hi     = cfg_addr[2];
  assign acc_ok = in_win && !(cfg_wide && hi);
  assign wr_ok  = cfg_we && acc_ok && !busy_i;
  assign cmd_wr = wr_ok && (sel == SLOT_CMD) && !hi;

  function automatic logic [REG_W-1:0] merge(input logic [REG_W-1:0] old,
                                             input logic [REG_W-1:0] nw,
                                             input logic wide, input logic upper);
    if (wide)       return nw;
    else if (upper) return {nw[HALF-1:0], old[HALF-1:0]};
    else            return {old[REG_W-1:HALF], nw[HALF-1:0]};
  endfunction

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_comb begin
      slot_d[g] = slot_q[g];
      if (wr_ok && (sel == 2'(g))) slot_d[g] = merge(slot_q[g], cfg_wdata, cfg_wide, hi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q[g] <= '0;
      else if (wr_ok) slot_q[g] <= slot_d[g];
    end
  end

  always_comb begin
    dir_d = dir_q;
    irq_d = irq_q;
    if (cmd_wr) begin
      dir_d = cfg_wdata[CMD_DIR];
      irq_d = cfg_wdata[CMD_IRQ];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (cmd_wr) begin
      dir_q <= dir_d;
      irq_q <= irq_d;
    end
  end

  assign start_o  = cmd_wr && cfg_wdata[CMD_GO];
  assign src_o    = slot_q[SLOT_SRC];
  assign dst_o    = slot_q[SLOT_DST];
  assign cnt_o    = slot_q[SLOT_CNT];
  assign dir_o    = dir_q;
  assign irq_en_o = irq_q;

  always_comb begin
    case (sel)
      SLOT_SRC: val = slot_q[SLOT_SRC];
      SLOT_DST: val = slot_q[SLOT_DST];
      SLOT_CNT: val = slot_q[SLOT_CNT];
      default:  val = {{(REG_W-3){1'b0}}, irq_q, dir_q, busy_i};
    endcase
    if (!acc_ok)       cfg_rdata = '0;
    else if (cfg_wide) cfg_rdata = val;
    else               cfg_rdata = {{HALF{1'b0}}, hi ? val[REG_W-1:HALF] : val[HALF-1:0]};
  end

  // R10: a job in flight freezes the whole configuration
  assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && cfg_we |=> $stable(slot_q) && $stable(dir_q) && $stable(irq_q));
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_buf_pkg::*;
#(
  parameter int               MASK_BITS = 28,
  parameter logic [REG_W-1:0] BUF_BASE  = 64'h4_0000,
  parameter int               BUF_BYTES = 4096,
  parameter int               BI_W      = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic [REG_W-1:0] cnt_i,
  input  logic             dir_i,
  input  logic             irq_en_i,
  output logic             busy_o,
  output logic             done_irq_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [REG_W-1:0] mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  input  logic [7:0]       mem_rdata_i,
  input  logic             mem_ack_i,
  output logic             buf_we_o,
  output logic [BI_W-1:0]  buf_idx_o,
  output logic [7:0]       buf_wdata_o,
  input  logic [7:0]       buf_rdata_i
);
  localparam int               CI_W    = BI_W + 1;
  localparam logic [REG_W-1:0] BYTES_L = REG_W'(BUF_BYTES);

  xfer_state_e      st_q, st_d;
  logic [CI_W-1:0]  idx_q, idx_d;
  logic             upd;
  logic [REG_W-1:0] host, dev, dev_off;
  logic             host_ok, dev_ok, last;

  assign host    = dir_i ? dst_i : src_i;
  assign dev     = dir_i ? src_i : dst_i;
  assign dev_off = dev - BUF_BASE;
  assign host_ok = (host[REG_W-1:MASK_BITS] == '0);
  assign dev_ok  = (dev >= BUF_BASE) && (cnt_i <= BYTES_L) && (dev_off <= BYTES_L - cnt_i);
  assign last    = (idx_q + 1'b1) == cnt_i[CI_W-1:0];

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d  = ST_CHECK;
        idx_d = '0;
      end
      ST_CHECK: begin
        if (!(host_ok && dev_ok)) st_d = ST_IDLE;
        else if (cnt_i == '0)     st_d = ST_DONE;
        else                      st_d = ST_MOVE;
      end
      ST_MOVE: if (mem_ack_i) begin
        idx_d = idx_q + 1'b1;
        if (last) st_d = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign upd = start_i || (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else if (upd) begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_irq_o  = (st_q == ST_DONE) && irq_en_i;
  assign mem_req_o   = (st_q == ST_MOVE);
  assign mem_we_o    = mem_req_o && dir_i;
  assign mem_addr_o  = host + REG_W'(idx_q);
  assign mem_wdata_o = buf_rdata_i;
  assign buf_idx_o   = dev_off[BI_W-1:0] + idx_q[BI_W-1:0];
  assign buf_we_o    = mem_req_o && !dir_i && mem_ack_i;
  assign buf_wdata_o = mem_rdata_i;

  // R6: an open request keeps its address, direction and data until acknowledged
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o));
  // R3: an accepted start shows up as busy on the next cycle
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  // R7: completion pulse lasts one cycle and busy is gone after it
  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq_o |=> !done_irq_o && !busy_o);
  // R8: no memory traffic outside a job
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o && !buf_we_o);
endmodule

// File: rtl/hostbuf_dma.sv
module hostbuf_dma
  import dma_buf_pkg::*;
#(
  parameter int               MASK_BITS = 28,
  parameter logic [REG_W-1:0] BUF_BASE  = 64'h4_0000,
  parameter int               BUF_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_wide,
  input  logic [7:0]  cfg_addr,
  input  logic [63:0] cfg_wdata,
  output logic [63:0] cfg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_ack,
  output logic        done_irq
);
  localparam int BI_W = $clog2(BUF_BYTES);

  logic [1:0] rst_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  logic             busy, start, dir, irq_en;
  logic [REG_W-1:0] src, dst, cnt;
  logic             buf_we;
  logic [BI_W-1:0]  buf_idx;
  logic [7:0]       buf_wdata, buf_rdata;

  dma_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_s),
    .cfg_we    (cfg_we),
    .cfg_wide  (cfg_wide),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .busy_i    (busy),
    .start_o   (start),
    .src_o     (src),
    .dst_o     (dst),
    .cnt_o     (cnt),
    .dir_o     (dir),
    .irq_en_o  (irq_en)
  );

  dma_xfer_fsm #(
    .MASK_BITS (MASK_BITS),
    .BUF_BASE  (BUF_BASE),
    .BUF_BYTES (BUF_BYTES),
    .BI_W      (BI_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_s),
    .start_i     (start),
    .src_i       (src),
    .dst_i       (dst),
    .cnt_i       (cnt),
    .dir_i       (dir),
    .irq_en_i    (irq_en),
    .busy_o      (busy),
    .done_irq_o  (done_irq),
    .mem_req_o   (mem_req),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .mem_ack_i   (mem_ack),
    .buf_we_o    (buf_we),
    .buf_idx_o   (buf_idx),
    .buf_wdata_o (buf_wdata),
    .buf_rdata_i (buf_rdata)
  );

  dma_lbuf #(
    .DEPTH (BUF_BYTES),
    .IDX_W (BI_W)
  ) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .idx   (buf_idx),
    .wdata (buf_wdata),
    .rdata (buf_rdata)
  );
endmodule

// File: tb/hostbuf_dma_test.sv
`timescale 1ns/1ps
module hostbuf_dma_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        cfg_we, cfg_wide;
  logic [7:0]  cfg_addr;
  logic [63:0] cfg_wdata, cfg_rdata;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic        mem_ack = 1'b0;
  logic        done_irq;

  hostbuf_dma uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wide(cfg_wide), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .done_irq(done_irq)
  );

  int nvec = 0, nerr = 0;

  // host memory responder (sole writer of hmem and its counters)
  logic [7:0]  hmem [1024];
  int          ack_cnt = 0, req_cyc = 0, order_err = 0, irq_cnt = 0;
  int          wcnt = 0, pos = 0, seen_id = 0, wipe_seen = 0;
  int          lat_cfg = 0, xfer_id = 0, wipe_req = 0;
  logic [63:0] xfer_base = '0;
  logic        xfer_we = 1'b0;

  function automatic logic [7:0] pat(int i);
    return 8'(i * 13 + 7);
  endfunction

  always @(negedge clk) begin
    if (wipe_req != wipe_seen) begin
      wipe_seen = wipe_req;
      for (int i = 0; i < 1024; i++) hmem[i] = (i < 512) ? pat(i) : 8'hEE;
    end
    if (xfer_id != seen_id) begin
      seen_id = xfer_id;
      pos = 0;
    end
    if (done_irq) irq_cnt++;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      req_cyc++;
      if (wcnt >= lat_cfg) begin
        wcnt = 0;
        ack_cnt++;
        if (mem_addr !== xfer_base + 64'(pos) || mem_we !== xfer_we) order_err++;
        pos++;
        if (mem_we) hmem[mem_addr[9:0]] = mem_wdata;
        else        mem_rdata = hmem[mem_addr[9:0]];
        mem_ack = 1'b1;
      end else wcnt++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic w, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wide = w; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic w, output logic [63:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wide = w;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_idle(input string req, output int cyc);
    logic [63:0] v;
    cyc = 0;
    for (int n = 0; n < 5000; n++) begin
      rd(8'h98, 1'b1, v);
      if (!v[0]) break;
      cyc++;
    end
    if (cyc >= 5000) chk(req, 64'd1, 64'd0);
  endtask

  task automatic go(input logic [63:0] s, input logic [63:0] d, input logic [63:0] n,
                    input logic [63:0] cmd);
    xfer_base = cmd[1] ? d : s;
    xfer_we   = cmd[1];
    xfer_id++;
    wr(8'h80, 1'b1, s);
    wr(8'h88, 1'b1, d);
    wr(8'h90, 1'b1, n);
    wr(8'h98, 1'b1, cmd);
  endtask

  task automatic wipe();
    wipe_req++;
    repeat (2) @(negedge clk);
  endtask

  // job that must be dropped: no requests, no pulse, busy clears quickly
  task automatic expect_drop(input string req, input logic [63:0] s, input logic [63:0] d,
                             input logic [63:0] n, input logic [63:0] cmd);
    int b_req, b_irq, cyc;
    b_req = req_cyc; b_irq = irq_cnt;
    go(s, d, n, cmd);
    wait_idle(req, cyc);
    chk(req, 64'(req_cyc - b_req), 64'd0);
    chk(req, 64'(irq_cnt - b_irq), 64'd0);
    chk(req, 64'(cyc <= 2), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [63:0] v;
    int b_ack, b_err, b_irq, b_req, cyc, k, off;
    int lens [6] = '{1, 2, 3, 5, 16, 64};

    rst_n = 1'b0; cfg_we = 1'b0; cfg_wide = 1'b1; cfg_addr = 8'h00; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    wipe();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 mem_req", 64'(mem_req), 64'd0);
    chk("R1 done_irq", 64'(done_irq), 64'd0);
    rd(8'h80, 1'b1, v); chk("R1 src", v, 64'd0);
    rd(8'h88, 1'b1, v); chk("R1 dst", v, 64'd0);
    rd(8'h90, 1'b1, v); chk("R1 cnt", v, 64'd0);
    rd(8'h98, 1'b1, v); chk("R1 cmd", v, 64'd0);

    // R2: access widths and halves
    wr(8'h80, 1'b1, 64'h1111_2222_3333_4444);
    wr(8'h84, 1'b0, 64'h0000_0000_CAFE_F00D);
    rd(8'h80, 1'b1, v); chk("R2 wide", v, 64'hCAFE_F00D_3333_4444);
    rd(8'h84, 1'b0, v); chk("R2 upper half", v, 64'h0000_0000_CAFE_F00D);
    rd(8'h80, 1'b0, v); chk("R2 lower half", v, 64'h0000_0000_3333_4444);
    wr(8'h90, 1'b0, 64'hFFFF_FFFF_0000_0009);
    rd(8'h90, 1'b1, v); chk("R2 narrow write", v, 64'h0000_0000_0000_0009);

    // R3: command fields without start
    wr(8'h98, 1'b1, 64'h6);
    rd(8'h98, 1'b1, v); chk("R3 cmd store", v, 64'h6);
    wr(8'h98, 1'b1, 64'h0);

    // R4, R5, R6, R7: sweep lengths, window offsets and latencies
    k = 0;
    foreach (lens[li]) begin
      for (int oi = 0; oi < 3; oi++) begin
        off = (oi == 0) ? 0 : (oi == 1) ? 3 : 4096 - lens[li];
        lat_cfg = k % 4;
        b_ack = ack_cnt; b_err = order_err; b_irq = irq_cnt;
        go(64'h0800_0000 + 64'(k * 3), 64'h4_0000 + 64'(off), 64'(lens[li]), 64'h5);
        rd(8'h98, 1'b1, v); chk("R3 busy after start", 64'(v[0]), 64'd1);
        wait_idle("R4 done", cyc);
        chk("R6 handshakes in", 64'(ack_cnt - b_ack), 64'(lens[li]));
        chk("R6 order in", 64'(order_err - b_err), 64'd0);
        chk("R7 pulse in", 64'(irq_cnt - b_irq), 64'd1);
        wipe();
        b_ack = ack_cnt; b_err = order_err;
        go(64'h4_0000 + 64'(off), 64'h200, 64'(lens[li]), 64'h7);
        wait_idle("R5 done", cyc);
        chk("R6 handshakes out", 64'(ack_cnt - b_ack), 64'(lens[li]));
        chk("R6 order out", 64'(order_err - b_err), 64'd0);
        for (int i = 0; i < lens[li]; i++)
          chk("R4+R5 data", 64'(hmem[512 + i]), 64'(pat(k * 3 + i)));
        chk("R5 no overrun", 64'(hmem[512 + lens[li]]), 64'hEE);
        k++;
      end
    end

    // R8: device window violations
    lat_cfg = 1;
    expect_drop("R8 below base", 64'h100, 64'h3_FFFF, 64'd1, 64'h5);
    expect_drop("R8 too long", 64'h100, 64'h4_0000, 64'd4097, 64'h5);
    expect_drop("R8 past end", 64'h100, 64'h4_0FFF, 64'd2, 64'h5);
    expect_drop("R8 src past end", 64'h4_1000, 64'h200, 64'd1, 64'h7);

    // R9: host mask
    expect_drop("R9 src bit28", 64'h1000_0000, 64'h4_0000, 64'd1, 64'h5);
    expect_drop("R9 dst bit32", 64'h4_0000, 64'h1_0000_0000, 64'd1, 64'h7);
    b_ack = ack_cnt; b_err = order_err;
    go(64'h0FFF_FFF0, 64'h4_0000, 64'd2, 64'h1);
    wait_idle("R9 edge", cyc);
    chk("R9 mask edge accepted", 64'(ack_cnt - b_ack), 64'd2);
    chk("R9 mask edge order", 64'(order_err - b_err), 64'd0);

    // R11: zero count
    b_req = req_cyc; b_irq = irq_cnt;
    go(64'h100, 64'h4_0000, 64'd0, 64'h5);
    wait_idle("R11 done", cyc);
    chk("R11 no request", 64'(req_cyc - b_req), 64'd0);
    chk("R11 pulse", 64'(irq_cnt - b_irq), 64'd1);

    // R7: pulse disabled
    b_ack = ack_cnt; b_irq = irq_cnt;
    go(64'h100, 64'h4_0010, 64'd3, 64'h1);
    wait_idle("R7 done", cyc);
    chk("R7 no pulse", 64'(irq_cnt - b_irq), 64'd0);
    chk("R7 bytes", 64'(ack_cnt - b_ack), 64'd3);

    // R10: writes during a job and in its final cycle
    lat_cfg = 2;
    b_ack = ack_cnt;
    go(64'h0800_0010, 64'h4_0020, 64'd4, 64'h5);
    rd(8'h98, 1'b1, v); chk("R3 busy readback", v, 64'h5);
    wr(8'h80, 1'b1, 64'hDEAD);
    wr(8'h90, 1'b1, 64'd9);
    wr(8'h98, 1'b1, 64'h1);
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (done_irq) break;
    end
    cfg_we = 1'b1; cfg_addr = 8'h88; cfg_wide = 1'b1; cfg_wdata = 64'h777;
    @(negedge clk);
    cfg_we = 1'b0;
    #1 chk("R10 final-cycle write", cfg_rdata, 64'h4_0020);
    rd(8'h98, 1'b1, v); chk("R7 busy cleared", v, 64'h4);
    rd(8'h80, 1'b1, v); chk("R10 src kept", v, 64'h0800_0010);
    rd(8'h90, 1'b1, v); chk("R10 cnt kept", v, 64'd4);
    repeat (30) @(negedge clk);
    chk("R10 restart ignored", 64'(ack_cnt - b_ack), 64'd4);
    wr(8'h88, 1'b1, 64'h777);
    rd(8'h88, 1'b1, v); chk("R10 idle write", v, 64'h777);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule